// File: doc/BRIEF.md
# Legacy Disk Task File Register Bank

This block gives a host a byte-wide view of the classic disk task file while a storage controller's firmware logic sits on the other side. The host reads and writes registers through a plain address/strobe port. The device side takes each command the host issues. It then posts completion status, an error code and the remaining sector count back into the bank. Every register write is a single-cycle strobe. Read data is combinational and valid in the same cycle as the read strobe, so there is no valid/ready exchange and no back-pressure at either edge.

The sector count and the three address bytes each keep two values: the latest write and the one before it. A high-order-byte select bit in device control chooses which value a read returns, which serves 48-bit addressing. Any write to a command-block register clears that select bit again. The bank also provides the following:
- a 28-bit address assembled from the registers;
- the sector count with zero standing for 256;
- a busy interlock on command-block writes;
- soft reset through device control;
- a compatibility drive-address register;
- an interrupt that a status read clears and an auxiliary status read does not.

Top module: `tf_regbank`

## Requirements
- R1: Addresses 2 (sector count), 3, 4 and 5 (address bytes 7:0, 15:8, 23:16) each hold a latest and a previous value. An accepted host write moves latest to previous and stores the new byte. A read returns latest when device control bit 7 (HOB) is 0, and previous when it is 1.
- R2: Any accepted host write to addresses 1 to 7 forces HOB back to 0.
- R3: `sect_total` equals the latest sector count, except that a count of 0 gives 256.
- R4: A read of drive/head (address 6) returns bits 7 and 5 as 1, together with the stored bit 6 (address mode, 1 = LBA), bit 4 (drive number) and bits 3:0 (head). `lba_mode` follows bit 6.
- R5: `lba28` is {head bits, byte at 5, byte at 4, byte at 3}, all from the latest values.
- R6: A status read (address 7) returns {BSY, RDY, DWF, DSC, DRQ, CORR, 0, ERR}. While BSY is 1 it reads exactly 8'h80. RDY reads 0 after power-up and then follows `dev_ready` one cycle later.
- R7: A host write to address 7 sets BSY, clears the interrupt pending flag, and pulses `cmd_valid` with `cmd_code` on the next cycle. While BSY or soft reset is set, host writes to addresses 1 to 7 are ignored.
- R8: A `dev_post` while BSY clears BSY and sets pending. It also loads DWF, DSC, DRQ, CORR and ERR from `dev_stat` bits 5, 4, 3, 2 and 0, the error register from `dev_err`, and the latest sector count from `dev_count`. A post while not busy is ignored.
- R9: A read of the error register (address 1) returns the posted error byte with bits 5, 3 and 1 forced to 0.
- R10: A status read clears pending. A read of auxiliary status (address 8) returns the same byte and leaves pending unchanged.
- R11: `irq` is pending AND NOT nIEN, where nIEN is device control bit 1 and is 0 after power-on reset.
- R12: While device control bit 2 (SRST) is 1, `srst_out` is 1 and the bank holds the following at 0: the command-block registers (feature, count, address bytes, drive/head stored bits), BSY, the status and error bytes, and pending.
- R13: Address 9 reads as follows: bit 7 is 1; bit 6 is NOT `dev_writing`; bits 5:2 are the inverted head bits; bit 1 is 1; bit 0 is the drive number bit (0 when drive 0 is selected).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| hst_addr | input | 4 | Host register address |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data, valid while hst_rd |
| dev_ready | input | 1 | Device can accept commands |
| dev_writing | input | 1 | A media write is in progress |
| dev_post | input | 1 | Completion strobe |
| dev_stat | input | 8 | Completion status fields |
| dev_err | input | 8 | Completion error byte |
| dev_count | input | 8 | Sectors left untransferred |
| cmd_valid | output | 1 | One-cycle command issue pulse |
| cmd_code | output | 8 | Issued command byte |
| cmd_feature | output | 8 | Feature register |
| lba28 | output | 28 | Assembled 28-bit address |
| lba_mode | output | 1 | 1 = LBA addressing |
| sect_total | output | 9 | Sector count, 0 meaning 256 |
| srst_out | output | 1 | Soft reset held |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a completion that arrives while nIEN masks the interrupt. In that state, pending must survive without being visible on `irq`, and an auxiliary status read must not consume it. The bench drives it in a fixed order: it sets nIEN, issues a command, posts completion, reads auxiliary status, and only then clears nIEN. At that point `irq` must rise with no new post. It then reads status and watches `irq` fall.

// File: rtl/tf_pkg.sv
package tf_pkg;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam logic [AW-1:0] ADR_FEAT = 4'd1;
  localparam logic [AW-1:0] ADR_CNT  = 4'd2;
  localparam logic [AW-1:0] ADR_LBAL = 4'd3;
  localparam logic [AW-1:0] ADR_LBAM = 4'd4;
  localparam logic [AW-1:0] ADR_LBAH = 4'd5;
  localparam logic [AW-1:0] ADR_DH   = 4'd6;
  localparam logic [AW-1:0] ADR_CMD  = 4'd7;
  localparam logic [AW-1:0] ADR_CTL  = 4'd8;
  localparam logic [AW-1:0] ADR_DADR = 4'd9;
  localparam int NSHADOW = 4;
  localparam logic [DW-1:0] STAT_LOAD_MASK = 8'h3D;
  localparam logic [DW-1:0] ERR_LOAD_MASK  = 8'hD5;
  localparam logic [DW-1:0] STAT_BUSY_VAL  = 8'h80;
endpackage

// File: rtl/tf_shadow_reg.sv
module tf_shadow_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         host_we,
  input  logic [W-1:0] host_d,
  input  logic         dev_we,
  input  logic [W-1:0] dev_d,
  input  logic         sel_prev,
  output logic [W-1:0] rd_val,
  output logic [W-1:0] cur_val
);
  logic [W-1:0] cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else if (clr) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else if (dev_we) begin
      cur_q <= dev_d;
    end else if (host_we) begin
      prev_q <= cur_q;
      cur_q  <= host_d;
    end
  end

  assign rd_val  = sel_prev ? prev_q : cur_q;
  assign cur_val = cur_q;

  AST_SHADOW_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !clr && !dev_we) |=> (prev_q == $past(cur_q))); // R1
endmodule

// File: rtl/tf_status_ctrl.sv
module tf_status_ctrl
  import tf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dc_we,
  input  logic          dc_hob,
  input  logic          dc_srst,
  input  logic          dc_nien,
  input  logic          cb_we,
  input  logic          cmd_we,
  input  logic [DW-1:0] cmd_d,
  input  logic          stat_rd,
  input  logic          dev_ready,
  input  logic          dev_post,
  input  logic [DW-1:0] dev_stat,
  input  logic [DW-1:0] dev_err,
  output logic          bsy,
  output logic          srst,
  output logic          hob,
  output logic          irq,
  output logic          post_acc,
  output logic [DW-1:0] stat_val,
  output logic [DW-1:0] err_val,
  output logic          cmd_valid,
  output logic [DW-1:0] cmd_code
);
  logic          nien_q, pend_q, rdy_q;
  logic [DW-1:0] stat_q, err_q;

  assign post_acc = dev_post && bsy && !srst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hob       <= 1'b0;
      srst      <= 1'b0;
      nien_q    <= 1'b0;
      bsy       <= 1'b0;
      pend_q    <= 1'b0;
      rdy_q     <= 1'b0;
      stat_q    <= '0;
      err_q     <= '0;
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
    end else begin
      rdy_q     <= dev_ready;
      cmd_valid <= 1'b0;
      if (dc_we) begin
        hob    <= dc_hob;
        srst   <= dc_srst;
        nien_q <= dc_nien;
      end else if (cb_we) begin
        hob <= 1'b0;
      end
      if (srst) begin
        bsy    <= 1'b0;
        pend_q <= 1'b0;
        stat_q <= '0;
        err_q  <= '0;
      end else if (post_acc) begin
        bsy    <= 1'b0;
        pend_q <= 1'b1;
        stat_q <= dev_stat & STAT_LOAD_MASK;
        err_q  <= dev_err & ERR_LOAD_MASK;
      end else if (cmd_we) begin
        bsy       <= 1'b1;
        pend_q    <= 1'b0;
        cmd_valid <= 1'b1;
        cmd_code  <= cmd_d;
      end else if (stat_rd) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign stat_val = bsy ? STAT_BUSY_VAL : ({1'b0, rdy_q, 6'b0} | stat_q);
  assign err_val  = err_q;
  assign irq      = pend_q && !nien_q;

  AST_HOB_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_we && !dc_we) |=> !hob); // R2
  AST_CMD_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> (bsy && !pend_q && cmd_valid)); // R7
  AST_POST_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    post_acc |=> (!bsy && pend_q)); // R8
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !stat_rd && !cmd_we && !srst) |=> pend_q); // R10
  AST_SRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!bsy && !pend_q)); // R12
endmodule

// File: rtl/tf_regbank.sv
module tf_regbank
  import tf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    hst_addr,
  input  logic          hst_wr,
  input  logic          hst_rd,
  input  logic [7:0]    hst_wdata,
  output logic [7:0]    hst_rdata,
  input  logic          dev_ready,
  input  logic          dev_writing,
  input  logic          dev_post,
  input  logic [7:0]    dev_stat,
  input  logic [7:0]    dev_err,
  input  logic [7:0]    dev_count,
  output logic          cmd_valid,
  output logic [7:0]    cmd_code,
  output logic [7:0]    cmd_feature,
  output logic [27:0]   lba28,
  output logic          lba_mode,
  output logic [8:0]    sect_total,
  output logic          srst_out,
  output logic          irq
);
  logic          bsy, srst, hob, post_acc;
  logic [DW-1:0] stat_val, err_val;
  logic          cb_we, dc_we, cmd_we, stat_rd;
  logic [DW-1:0] sh_rd  [NSHADOW];
  logic [DW-1:0] sh_cur [NSHADOW];
  logic          lba_q, drv_q;
  logic [3:0]    head_q;
  logic [DW-1:0] feat_q;

  assign cb_we   = hst_wr && (hst_addr >= ADR_FEAT) && (hst_addr <= ADR_CMD) && !bsy && !srst;
  assign cmd_we  = cb_we && (hst_addr == ADR_CMD);
  assign dc_we   = hst_wr && (hst_addr == ADR_CTL);
  assign stat_rd = hst_rd && (hst_addr == ADR_CMD);

  for (genvar i = 0; i < NSHADOW; i++) begin : g_shadow
    tf_shadow_reg #(.W(DW)) u_sh (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (srst),
      .host_we  (cb_we && (hst_addr == ADR_CNT + 4'(i))),
      .host_d   (hst_wdata),
      .dev_we   ((i == 0) ? post_acc : 1'b0),
      .dev_d    (dev_count),
      .sel_prev (hob),
      .rd_val   (sh_rd[i]),
      .cur_val  (sh_cur[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lba_q  <= 1'b0;
      drv_q  <= 1'b0;
      head_q <= '0;
      feat_q <= '0;
    end else if (srst) begin
      lba_q  <= 1'b0;
      drv_q  <= 1'b0;
      head_q <= '0;
      feat_q <= '0;
    end else if (cb_we) begin
      if (hst_addr == ADR_DH) begin
        lba_q  <= hst_wdata[6];
        drv_q  <= hst_wdata[4];
        head_q <= hst_wdata[3:0];
      end
      if (hst_addr == ADR_FEAT) feat_q <= hst_wdata;
    end
  end

  tf_status_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .dc_we     (dc_we),
    .dc_hob    (hst_wdata[7]),
    .dc_srst   (hst_wdata[2]),
    .dc_nien   (hst_wdata[1]),
    .cb_we     (cb_we),
    .cmd_we    (cmd_we),
    .cmd_d     (hst_wdata),
    .stat_rd   (stat_rd),
    .dev_ready (dev_ready),
    .dev_post  (dev_post),
    .dev_stat  (dev_stat),
    .dev_err   (dev_err),
    .bsy       (bsy),
    .srst      (srst),
    .hob       (hob),
    .irq       (irq),
    .post_acc  (post_acc),
    .stat_val  (stat_val),
    .err_val   (err_val),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code)
  );

  always_comb begin
    hst_rdata = '0;
    if (hst_rd) begin
      case (hst_addr)
        ADR_FEAT: hst_rdata = err_val;
        ADR_CNT:  hst_rdata = sh_rd[0];
        ADR_LBAL: hst_rdata = sh_rd[1];
        ADR_LBAM: hst_rdata = sh_rd[2];
        ADR_LBAH: hst_rdata = sh_rd[3];
        ADR_DH:   hst_rdata = {1'b1, lba_q, 1'b1, drv_q, head_q};
        ADR_CMD:  hst_rdata = stat_val;
        ADR_CTL:  hst_rdata = stat_val;
        ADR_DADR: hst_rdata = {1'b1, !dev_writing, ~head_q, 1'b1, drv_q};
        default:  hst_rdata = '0;
      endcase
    end
  end

  assign lba28       = {head_q, sh_cur[3], sh_cur[2], sh_cur[1]};
  assign lba_mode    = lba_q;
  assign sect_total  = (sh_cur[0] == '0) ? 9'd256 : {1'b0, sh_cur[0]};
  assign cmd_feature = feat_q;
  assign srst_out    = srst;

  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && bsy && (hst_addr == ADR_DH)) |=> $stable(head_q)); // R7
endmodule

// File: tb/tf_regbank_tb_top.sv
module tf_regbank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] hst_addr = '0;
  logic hst_wr = 1'b0, hst_rd = 1'b0;
  logic [7:0] hst_wdata = '0;
  logic [7:0] hst_rdata;
  logic dev_ready = 1'b0, dev_writing = 1'b0, dev_post = 1'b0;
  logic [7:0] dev_stat = '0, dev_err = '0, dev_count = '0;
  logic cmd_valid;
  logic [7:0] cmd_code, cmd_feature;
  logic [27:0] lba28;
  logic lba_mode, srst_out, irq;
  logic [8:0] sect_total;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tf_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wr(hst_wr),
    .hst_rd(hst_rd), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .dev_ready(dev_ready), .dev_writing(dev_writing), .dev_post(dev_post),
    .dev_stat(dev_stat), .dev_err(dev_err), .dev_count(dev_count),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_feature(cmd_feature),
    .lba28(lba28), .lba_mode(lba_mode), .sect_total(sect_total),
    .srst_out(srst_out), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
    @(posedge clk); #1;
    hst_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    hst_addr = a; hst_rd = 1'b1;
    #1 d = hst_rdata;
    @(posedge clk); #1;
    hst_rd = 1'b0;
  endtask

  task automatic post(input logic [7:0] st, input logic [7:0] er, input logic [7:0] cn);
    @(negedge clk);
    dev_stat = st; dev_err = er; dev_count = cn; dev_post = 1'b1;
    @(posedge clk); #1;
    dev_post = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(4'd7, v);     chk("R6 status after reset", v, 8'h00);
    chk("R11 irq after reset", irq, 1'b0);
    rd(4'd6, v);     chk("R4 drive/head after reset", v, 8'hA0);
    chk("R3 zero count means 256", sect_total, 9'd256);
  endtask

  task automatic t_shadow();
    logic [7:0] v;
    wr(4'd2, 8'h11); wr(4'd2, 8'h22);
    rd(4'd2, v);     chk("R1 latest count", v, 8'h22);
    chk("R3 sect_total", sect_total, 9'd34);
    wr(4'd8, 8'h80);
    rd(4'd2, v);     chk("R1 previous count with HOB", v, 8'h11);
    wr(4'd3, 8'h33);
    rd(4'd2, v);     chk("R2 HOB cleared by write", v, 8'h22);
  endtask

  task automatic t_lba();
    logic [7:0] v;
    wr(4'd3, 8'h44); wr(4'd4, 8'h55); wr(4'd5, 8'h66); wr(4'd6, 8'hE7);
    chk("R5 lba28", lba28, 28'h7665544);
    chk("R4 lba_mode", lba_mode, 1'b1);
    rd(4'd6, v);     chk("R4 drive/head read", v, 8'hE7);
    wr(4'd6, 8'h03);
    rd(4'd6, v);     chk("R4 CHS read", v, 8'hA3);
    chk("R4 lba_mode CHS", lba_mode, 1'b0);
    rd(4'd9, v);     chk("R13 drive address idle", v, 8'hF2);
    dev_writing = 1'b1;
    rd(4'd9, v);     chk("R13 drive address writing", v, 8'hB2);
    dev_writing = 1'b0;
  endtask

  task automatic t_cmd();
    logic [7:0] v;
    dev_ready = 1'b1;
    @(posedge clk);
    rd(4'd7, v);     chk("R6 RDY follows device", v, 8'h40);
    wr(4'd1, 8'h5A);
    chk("R7 feature stored", cmd_feature, 8'h5A);
    wr(4'd7, 8'h20);
    chk("R7 cmd_valid pulse", cmd_valid, 1'b1);
    chk("R7 cmd_code", cmd_code, 8'h20);
    @(posedge clk); #1;
    chk("R7 pulse one cycle", cmd_valid, 1'b0);
    rd(4'd7, v);     chk("R6 busy reads 80", v, 8'h80);
    wr(4'd3, 8'h99);
    rd(4'd3, v);     chk("R7 write ignored while busy", v, 8'h44);
    post(8'hD1, 8'hFF, 8'h05);
    chk("R8 irq after post", irq, 1'b1);
    rd(4'd8, v);     chk("R10 aux status value", v, 8'h51);
    chk("R10 aux read keeps irq", irq, 1'b1);
    rd(4'd1, v);     chk("R9 error reserved bits", v, 8'hD5);
    rd(4'd2, v);     chk("R8 remaining count", v, 8'h05);
    post(8'h00, 8'h00, 8'h00);
    rd(4'd2, v);     chk("R8 post ignored when idle", v, 8'h05);
    rd(4'd7, v);     chk("R6 status value", v, 8'h51);
    chk("R10 status read clears irq", irq, 1'b0);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    wr(4'd8, 8'h02);
    wr(4'd7, 8'hC8);
    post(8'h10, 8'h00, 8'h00);
    chk("R11 irq masked by nIEN", irq, 1'b0);
    rd(4'd8, v);
    wr(4'd8, 8'h00);
    chk("R11 irq after unmask", irq, 1'b1);
    rd(4'd7, v);     chk("R8 success status", v, 8'h50);
    chk("R10 cleared", irq, 1'b0);
  endtask

  task automatic t_srst();
    logic [7:0] v;
    wr(4'd3, 8'h77);
    wr(4'd8, 8'h04);
    chk("R12 srst_out", srst_out, 1'b1);
    @(posedge clk); #1;
    rd(4'd3, v);     chk("R12 address cleared", v, 8'h00);
    wr(4'd7, 8'h30);
    chk("R12 command ignored in reset", cmd_valid, 1'b0);
    wr(4'd8, 8'h00);
    chk("R12 srst released", srst_out, 1'b0);
    rd(4'd7, v);     chk("R12 not busy after reset", v, 8'h40);
    rd(4'd3, v);     chk("R12 address stays cleared", v, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_shadow();
    t_lba();
    t_cmd();
    t_mask();
    t_srst();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule